// File: doc/BRIEF.md
# Accumulator ALU with Flag Generation

This block is the arithmetic and logic unit of an 8-bit accumulator machine. Each operation takes three inputs: the accumulator value, a second operand, and the incoming flags. The second operand is either the companion register B or a byte from memory. The block returns the new accumulator, the new companion register, and the flags: carry (CY), half-carry (AC), overflow (OV) and parity (P). The surrounding core does the operand fetch and the write-back. It presents the current values, pulses `start` with an operation code, and later reads the registered results.

Most operations take a single cycle. These are add, add with carry, subtract with borrow, increment, decrement, AND, OR, XOR, clear, complement, the four rotates, nibble swap and decimal adjust. Multiply and divide run as an eight-step shift-and-add or shift-and-subtract sequence. During that sequence `busy` is high, and `done` marks the cycle in which the results appear. Each operation has its own rule for which flags it writes. A flag that an operation does not write is passed through from its input. Parity always follows the accumulator output.

Top module: `acc_alu`

## Requirements
- R1: After a synchronous reset, `acc_out`, `b_out`, `cy_out`, `ac_out`, `ov_out`, `p_out`, `busy` and `done` are all 0.
- R2: Operation code 0 (add) yields `acc_in + opnd_in`, and code 1 (add with carry) yields `acc_in + opnd_in + cy_in`, both modulo 256. CY is the carry out of bit 7, AC is the carry out of bit 3, and OV is set when the signed 8-bit result overflows.
- R3: Operation code 2 (subtract with borrow) yields `acc_in - opnd_in - cy_in` modulo 256. CY is the borrow out of bit 7, AC is the borrow out of bit 3, and OV is set on signed overflow.
- R4: The following operations leave CY, AC and OV equal to `cy_in`, `ac_in` and `ov_in`: codes 3 (increment A), 4 (decrement A), 5 (AND), 6 (OR), 7 (XOR), 8 (clear A to 0) and 9 (complement A).
- R5: Code 10 rotates A left, with bit 7 going into bit 0. Code 12 rotates A right, with bit 0 going into bit 7. Code 14 exchanges the two nibbles of A. These three codes leave all flags unchanged. Codes 11 and 13 rotate the 9-bit ring {CY, A} left and right respectively. They write only CY.
- R6: Code 15 (decimal adjust) first adds 06h when `ac_in` is 1 or the low nibble of A is above 9. It then adds 60h when `cy_in` is 1, when the first step carried, or when the high nibble is above 9. CY becomes 1 if `cy_in` is 1 or either step carried, and AC and OV are unchanged.
- R7: Code 16 (multiply) puts the low byte of `acc_in * opnd_in` in `acc_out` and the high byte in `b_out`. It clears CY, sets OV when the product exceeds FFh, and keeps the AC value captured at start. Results appear on the 8th clock edge after the start edge.
- R8: Code 17 (divide) puts the quotient `acc_in / opnd_in` in `acc_out` and the remainder in `b_out`, clears CY and OV, and keeps AC. A zero divisor sets OV and clears CY. `acc_out` and `b_out` then take values that hold steady until the next operation.
- R9: `p_out` is 1 exactly when `acc_out` holds an odd number of ones.
- R10: `busy` is high from the start edge of a multiply or divide until its result edge. `start` is ignored while `busy` is high, and `busy` and `done` are never high together.
- R11: For codes 0 to 15, `b_out` takes the value of `opnd_in` at the start edge.
- R12: For codes 0 to 15, the results and a one-cycle `done` pulse appear on the clock edge that samples `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the operation given by `op` |
| op | input | 5 | Operation code (0 to 17) |
| acc_in | input | 8 | Current accumulator |
| opnd_in | input | 8 | Second operand (register B or memory byte) |
| cy_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current half-carry flag |
| ov_in | input | 1 | Current overflow flag |
| acc_out | output | 8 | New accumulator |
| b_out | output | 8 | New companion register |
| cy_out | output | 1 | New carry flag |
| ac_out | output | 1 | New half-carry flag |
| ov_out | output | 1 | New overflow flag |
| p_out | output | 1 | Parity of `acc_out` |
| busy | output | 1 | Multiply or divide in progress |
| done | output | 1 | Results updated this cycle |

## Verification
The hardest situation to reach from the ports is a start request that arrives while a multiply is still stepping, because such a request must leave both the sequence and the outputs untouched. The stimulus issues a multiply and then holds `start` high with a different operation for several of its busy cycles. It also drives random operations against a behavioural model that tracks `busy` on its own. A zero divisor is a second hard case. It is forced directly, and the outputs are then watched over idle cycles for stability.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;
    localparam int DW = 8;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,  OP_ADDC = 5'd1,  OP_SUBB = 5'd2,  OP_INC  = 5'd3,
        OP_DEC  = 5'd4,  OP_AND  = 5'd5,  OP_OR   = 5'd6,  OP_XOR  = 5'd7,
        OP_CLR  = 5'd8,  OP_CPL  = 5'd9,  OP_RL   = 5'd10, OP_RLC  = 5'd11,
        OP_RR   = 5'd12, OP_RRC  = 5'd13, OP_SWAP = 5'd14, OP_DA   = 5'd15,
        OP_MUL  = 5'd16, OP_DIV  = 5'd17
    } alu_op_e;

    typedef struct packed {
        logic cy;
        logic ac;
        logic ov;
    } flags_t;

    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        flags_t        f;
    } alu_res_t;

    function automatic logic odd_par(input logic [DW-1:0] v);
        return ^v;
    endfunction

    function automatic logic is_iter(input alu_op_e o);
        return (o == OP_MUL) || (o == OP_DIV);
    endfunction
endpackage

// File: rtl/acc_alu_single.sv
`timescale 1ns/1ps
module acc_alu_single
    import acc_alu_pkg::*;
#(
    parameter int W = DW
) (
    input  alu_op_e       op_e,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  flags_t        fin,
    output alu_res_t      res
);
    localparam int NB = W / 2;

    logic          cin;
    logic [W:0]    wide;
    logic [NB:0]   half;
    logic          lo_fix, hi_fix;
    logic [W:0]    t1, t2;

    always_comb begin
        res    = '{a: a, b: b, f: fin};
        cin    = (op_e == OP_ADDC || op_e == OP_SUBB) ? fin.cy : 1'b0;
        wide   = '0;
        half   = '0;
        lo_fix = 1'b0;
        hi_fix = 1'b0;
        t1     = '0;
        t2     = '0;
        unique case (op_e)
            OP_ADD, OP_ADDC: begin
                wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
                half = {1'b0, a[NB-1:0]} + {1'b0, b[NB-1:0]} + {{NB{1'b0}}, cin};
                res.a    = wide[W-1:0];
                res.f.cy = wide[W];
                res.f.ac = half[NB];
                res.f.ov = (a[W-1] == b[W-1]) && (wide[W-1] != a[W-1]);
            end
            OP_SUBB: begin
                wide = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
                half = {1'b0, a[NB-1:0]} - {1'b0, b[NB-1:0]} - {{NB{1'b0}}, cin};
                res.a    = wide[W-1:0];
                res.f.cy = wide[W];
                res.f.ac = half[NB];
                res.f.ov = (a[W-1] != b[W-1]) && (wide[W-1] != a[W-1]);
            end
            OP_INC:  res.a = a + W'(1);
            OP_DEC:  res.a = a - W'(1);
            OP_AND:  res.a = a & b;
            OP_OR:   res.a = a | b;
            OP_XOR:  res.a = a ^ b;
            OP_CLR:  res.a = '0;
            OP_CPL:  res.a = ~a;
            OP_RL:   res.a = {a[W-2:0], a[W-1]};
            OP_RR:   res.a = {a[0], a[W-1:1]};
            OP_RLC: begin
                res.a    = {a[W-2:0], fin.cy};
                res.f.cy = a[W-1];
            end
            OP_RRC: begin
                res.a    = {fin.cy, a[W-1:1]};
                res.f.cy = a[0];
            end
            OP_SWAP: res.a = {a[NB-1:0], a[W-1:NB]};
            OP_DA: begin
                lo_fix   = fin.ac || (a[NB-1:0] > NB'(9));
                t1       = {1'b0, a} + (lo_fix ? (W+1)'(6) : '0);
                hi_fix   = fin.cy || t1[W] || (t1[W-1:NB] > NB'(9));
                t2       = {1'b0, t1[W-1:0]} + (hi_fix ? (W+1)'(8'h60) : '0);
                res.a    = t2[W-1:0];
                res.f.cy = fin.cy || t1[W] || t2[W];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_alu_iter.sv
`timescale 1ns/1ps
module acc_alu_iter #(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          div_sel,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic          running,
    output logic          last,
    output logic          div_mode,
    output logic          zero_div,
    output logic [W-1:0]  nxt_hi,
    output logic [W-1:0]  nxt_lo
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    logic [W-1:0]  hi_q, lo_q, dv_q;
    logic [CW-1:0] cnt_q;
    logic          run_q, mode_q;
    logic [W:0]    shifted, diff, summed;
    logic          fits;

    always_comb begin
        shifted = {hi_q, lo_q[W-1]};
        diff    = shifted - {1'b0, dv_q};
        fits    = shifted >= {1'b0, dv_q};
        summed  = {1'b0, hi_q} + (lo_q[0] ? {1'b0, dv_q} : '0);
        if (mode_q) begin
            nxt_hi = fits ? diff[W-1:0] : shifted[W-1:0];
            nxt_lo = {lo_q[W-2:0], fits};
        end else begin
            nxt_hi = summed[W:1];
            nxt_lo = {summed[0], lo_q[W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q   <= '0;
            lo_q   <= '0;
            dv_q   <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            mode_q <= 1'b0;
        end else if (load && !run_q) begin
            hi_q   <= '0;
            lo_q   <= a;
            dv_q   <= b;
            cnt_q  <= '0;
            run_q  <= 1'b1;
            mode_q <= div_sel;
        end else if (run_q) begin
            hi_q  <= nxt_hi;
            lo_q  <= nxt_lo;
            cnt_q <= cnt_q + CW'(1);
            if (cnt_q == LAST_STEP) run_q <= 1'b0;
        end
    end

    assign running  = run_q;
    assign last     = run_q && (cnt_q == LAST_STEP);
    assign div_mode = mode_q;
    assign zero_div = (dv_q == '0);
endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W = DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [4:0]    op,
    input  logic [W-1:0]  acc_in,
    input  logic [W-1:0]  opnd_in,
    input  logic          cy_in,
    input  logic          ac_in,
    input  logic          ov_in,
    output logic [W-1:0]  acc_out,
    output logic [W-1:0]  b_out,
    output logic          cy_out,
    output logic          ac_out,
    output logic          ov_out,
    output logic          p_out,
    output logic          busy,
    output logic          done
);
    alu_op_e   op_e;
    alu_res_t  one_res;
    flags_t    fin;
    logic      accept, iter_run, iter_last, iter_div, iter_zero, ac_hold;
    logic [W-1:0] iter_hi, iter_lo;

    assign op_e   = alu_op_e'(op);
    assign fin    = '{cy: cy_in, ac: ac_in, ov: ov_in};
    assign accept = start && !iter_run;

    acc_alu_single #(.W(W)) u_single (
        .op_e (op_e),
        .a    (acc_in),
        .b    (opnd_in),
        .fin  (fin),
        .res  (one_res)
    );

    acc_alu_iter #(.W(W)) u_iter (
        .clk      (clk),
        .rst      (rst),
        .load     (start && is_iter(op_e)),
        .div_sel  (op_e == OP_DIV),
        .a        (acc_in),
        .b        (opnd_in),
        .running  (iter_run),
        .last     (iter_last),
        .div_mode (iter_div),
        .zero_div (iter_zero),
        .nxt_hi   (iter_hi),
        .nxt_lo   (iter_lo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_out <= '0;
            b_out   <= '0;
            cy_out  <= 1'b0;
            ac_out  <= 1'b0;
            ov_out  <= 1'b0;
            p_out   <= 1'b0;
            done    <= 1'b0;
            ac_hold <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept && !is_iter(op_e)) begin
                acc_out <= one_res.a;
                b_out   <= one_res.b;
                cy_out  <= one_res.f.cy;
                ac_out  <= one_res.f.ac;
                ov_out  <= one_res.f.ov;
                p_out   <= odd_par(one_res.a);
                done    <= 1'b1;
            end else if (accept) begin
                ac_hold <= ac_in;
            end else if (iter_last) begin
                acc_out <= iter_lo;
                b_out   <= iter_hi;
                cy_out  <= 1'b0;
                ac_out  <= ac_hold;
                ov_out  <= iter_div ? iter_zero : (iter_hi != '0);
                p_out   <= odd_par(iter_lo);
                done    <= 1'b1;
            end
        end
    end

    assign busy = iter_run;
endmodule

// File: rtl/acc_alu_chk.sv
`timescale 1ns/1ps
module acc_alu_chk
    import acc_alu_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [4:0]  op,
    input logic        cy_in,
    input logic        ac_in,
    input logic        ov_in,
    input logic [7:0]  acc_out,
    input logic [7:0]  b_out,
    input logic        cy_out,
    input logic        ac_out,
    input logic        ov_out,
    input logic        p_out,
    input logic        busy,
    input logic        done
);
    // R9
    parity_track_chk: assert property (@(posedge clk) disable iff (rst)
        p_out == ^acc_out);

    // R10
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R10
    hold_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |-> $stable(acc_out) && $stable(b_out));

    // R7
    iter_enter_chk: assert property (@(posedge clk) disable iff (rst)
        start && !busy && (op == 5'd16 || op == 5'd17) |=> busy);

    // R12
    single_done_chk: assert property (@(posedge clk) disable iff (rst)
        start && !busy && op < 5'd16 |=> done && !busy);

    // R4
    flags_kept_chk: assert property (@(posedge clk) disable iff (rst)
        start && !busy && op >= 5'd3 && op <= 5'd9 |=>
        cy_out == $past(cy_in) && ac_out == $past(ac_in) && ov_out == $past(ov_in));

    // R7
    iter_cy_clear_chk: assert property (@(posedge clk) disable iff (rst)
        done && $past(busy) |-> !cy_out);
endmodule

bind acc_alu acc_alu_chk u_chk (.*);

// File: tb/acc_alu_tb_top.sv
`timescale 1ns/1ps
module acc_alu_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [4:0] op = '0;
    logic [7:0] acc_in = '0, opnd_in = '0;
    logic       cy_in = 1'b0, ac_in = 1'b0, ov_in = 1'b0;
    logic [7:0] acc_out, b_out;
    logic       cy_out, ac_out, ov_out, p_out, busy, done;

    always #2 clk = ~clk;

    acc_alu dut_i (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .acc_in(acc_in), .opnd_in(opnd_in),
        .cy_in(cy_in), .ac_in(ac_in), .ov_in(ov_in),
        .acc_out(acc_out), .b_out(b_out),
        .cy_out(cy_out), .ac_out(ac_out), .ov_out(ov_out),
        .p_out(p_out), .busy(busy), .done(done)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit cmp_en = 0;
    string cur_req = "R1";

    // reference state
    int m_a = 0, m_b = 0, m_cy = 0, m_ac = 0, m_ov = 0;
    int m_busy = 0, m_done = 0, m_left = 0;
    bit m_unk = 0, m_iter_last = 0;
    int p_a, p_b, p_ov, p_ac;
    bit p_unk;

    function automatic int sgn8(int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    function automatic int ones(int v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (v >> i) & 1;
        return n;
    endfunction

    task automatic model_single(int o, int a, int b, int c, int h, int v);
        int r, s, cc;
        m_cy = c; m_ac = h; m_ov = v; m_b = b; r = a;
        case (o)
            0, 1: begin
                cc = (o == 1) ? c : 0;
                r = a + b + cc;
                m_cy = (r > 255);
                m_ac = ((a % 16) + (b % 16) + cc) > 15;
                s = sgn8(a) + sgn8(b) + cc;
                m_ov = (s > 127 || s < -128);
            end
            2: begin
                r = a - b - c;
                m_cy = (r < 0);
                m_ac = ((a % 16) - (b % 16) - c) < 0;
                s = sgn8(a) - sgn8(b) - c;
                m_ov = (s > 127 || s < -128);
            end
            3: r = a + 1;
            4: r = a + 255;
            5: r = a & b;
            6: r = a | b;
            7: r = a ^ b;
            8: r = 0;
            9: r = 255 - a;
            10: r = (a * 2) + (a / 128);
            11: begin r = (a * 2) + c; m_cy = a / 128; end
            12: r = (a / 2) + (a % 2) * 128;
            13: begin r = (a / 2) + c * 128; m_cy = a % 2; end
            14: r = (a % 16) * 16 + (a / 16);
            15: begin
                cc = c;
                if (h == 1 || (a % 16) > 9) r = a + 6;
                if (r > 255) cc = 1;
                r = r % 256;
                if (cc == 1 || (r / 16) > 9) begin
                    r = r + 96;
                    if (r > 255) cc = 1;
                end
                m_cy = cc;
            end
            default: ;
        endcase
        m_a = ((r % 256) + 256) % 256;
        m_unk = 0;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_a = 0; m_b = 0; m_cy = 0; m_ac = 0; m_ov = 0;
            m_busy = 0; m_done = 0; m_left = 0; m_unk = 0; m_iter_last = 0;
        end else begin
            m_done = 0;
            if (start && m_busy == 0) begin
                if (op < 16) begin
                    model_single(op, acc_in, opnd_in, cy_in, ac_in, ov_in);
                    m_done = 1; m_iter_last = 0;
                end else begin
                    m_busy = 1; m_left = 8; p_ac = ac_in; p_unk = 0;
                    if (op == 16) begin
                        p_a = (acc_in * opnd_in) % 256;
                        p_b = (acc_in * opnd_in) / 256;
                        p_ov = (acc_in * opnd_in) > 255;
                    end else if (opnd_in == 0) begin
                        p_a = 0; p_b = 0; p_ov = 1; p_unk = 1;
                    end else begin
                        p_a = acc_in / opnd_in;
                        p_b = acc_in % opnd_in;
                        p_ov = 0;
                    end
                end
            end else if (m_busy == 1) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0; m_done = 1; m_iter_last = 1;
                    m_a = p_a; m_b = p_b; m_cy = 0; m_ov = p_ov; m_ac = p_ac;
                    m_unk = p_unk;
                end
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && !finished) begin
            chk("R10", "busy", busy, m_busy);
            chk((m_iter_last ? "R10" : "R12"), "done", done, m_done);
            chk(cur_req, "cy", cy_out, m_cy);
            chk(cur_req, "ac", ac_out, m_ac);
            chk(cur_req, "ov", ov_out, m_ov);
            chk("R9", "parity", p_out, ones(acc_out) % 2);
            if (!m_unk) begin
                chk(cur_req, "acc", acc_out, m_a);
                chk((m_iter_last ? cur_req : "R11"), "b", b_out, m_b);
            end
        end
    end

    task automatic issue(string req, int o, int a, int b, int c, int h, int v);
        @(negedge clk);
        cur_req = req;
        op = 5'(o); acc_in = 8'(a); opnd_in = 8'(b);
        cy_in = 1'(c); ac_in = 1'(h); ov_in = 1'(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (o >= 16) repeat (9) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired in %s", cur_req);
        finish_run();
    end

    initial begin
        logic [7:0] snap_a, snap_b;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp_en = 1;               // R1 reset values compared here
        @(negedge clk);
        rst = 1'b0;
        // R2 add and add with carry
        issue("R2", 0, 8'h7F, 8'h01, 0, 0, 0);
        issue("R2", 0, 8'hFF, 8'h01, 0, 0, 0);
        issue("R2", 1, 8'h0F, 8'h00, 1, 0, 0);
        issue("R2", 1, 8'h80, 8'h80, 1, 0, 0);
        // R3 subtract with borrow
        issue("R3", 2, 8'h00, 8'h01, 0, 0, 0);
        issue("R3", 2, 8'h80, 8'h01, 0, 0, 0);
        issue("R3", 2, 8'h50, 8'h20, 1, 0, 0);
        // R4 flags held
        issue("R4", 3, 8'hFF, 8'h00, 1, 0, 1);
        issue("R4", 4, 8'h00, 8'h00, 0, 1, 0);
        issue("R4", 5, 8'hF0, 8'h3C, 1, 1, 1);
        issue("R4", 6, 8'h0F, 8'h30, 0, 1, 1);
        issue("R4", 7, 8'hAA, 8'hFF, 1, 0, 0);
        issue("R4", 8, 8'h5A, 8'h00, 1, 1, 0);
        issue("R4", 9, 8'h5A, 8'h00, 0, 0, 1);
        // R5 rotates and swap
        issue("R5", 10, 8'h81, 0, 0, 1, 0);
        issue("R5", 11, 8'h81, 0, 0, 0, 1);
        issue("R5", 12, 8'h01, 0, 1, 0, 0);
        issue("R5", 13, 8'h02, 0, 1, 1, 0);
        issue("R5", 14, 8'h3C, 0, 0, 0, 0);
        // R6 decimal adjust
        issue("R6", 15, 8'h9A, 0, 0, 0, 0);
        issue("R6", 15, 8'h15, 0, 0, 1, 0);
        issue("R6", 15, 8'h45, 0, 1, 0, 1);
        issue("R6", 15, 8'h34, 0, 0, 0, 0);
        // R7 multiply
        issue("R7", 16, 8'h50, 8'hA0, 1, 1, 0);
        issue("R7", 16, 8'h03, 8'h04, 1, 0, 1);
        // R8 divide
        issue("R8", 17, 200, 7, 1, 0, 1);
        issue("R8", 17, 5, 9, 0, 1, 0);
        issue("R8", 17, 77, 0, 1, 0, 0);
        @(negedge clk);
        snap_a = acc_out; snap_b = b_out;
        repeat (3) @(negedge clk);
        chk("R8", "acc stable after zero divisor", acc_out, snap_a);
        chk("R8", "b stable after zero divisor", b_out, snap_b);
        // R10 start held high during a multiply is ignored
        @(negedge clk);
        cur_req = "R10";
        op = 5'd16; acc_in = 8'hFF; opnd_in = 8'hFF; start = 1'b1;
        @(negedge clk);
        op = 5'd0; acc_in = 8'h11; opnd_in = 8'h22;
        repeat (4) @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        // mixed traffic
        for (int k = 0; k < 300; k++) begin
            int o;
            o = $urandom_range(17, 0);
            issue((o < 16) ? "R12" : ((o == 16) ? "R7" : "R8"), o,
                  $urandom_range(255, 0), $urandom_range(255, 0),
                  $urandom_range(1, 0), $urandom_range(1, 0), $urandom_range(1, 0));
        end
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule